// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block collects frequency-word samples from a phase-locked loop while that loop is locked, and keeps a running average that a holdover controller can use once the input reference is lost. Samples reach the block on a valid/ready stream, at a nominal period of 268 ns, but the logic accepts one sample per clock. The average covers a window of `2^L - 1` samples. The most recent `2^Dx` samples are left out of the window, so that data disturbed just before an input failure never reaches the holdover value. `L` and `Dx` are 5-bit exponents. Both are clamped to the parameter `MAX_EXP`, which sets the depth of the sample ring.

The lock indication controls the block. When the loop gains lock, the history is cleared and both exponents are captured for the whole lock session. While the loop is locked, samples are accepted and the average is updated. When lock is lost, the ready signal drops and the average and the history-valid flag are frozen, so the holdover logic sees a stable value. The average is formed by shifting the window sum right by `L`, which divides by `2^L` and not by the true window length `2^L - 1`.

Back-pressure rules: `s_ready` is high only when `locked` is high on this cycle and was high on the previous cycle. A sample transfers on a clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, the block takes nothing and keeps nothing, so any sample offered then is dropped. A sender does not need to hold data while the loop is unlocked.

Top module: `freq_hist_avg`

## Requirements
- R1: After reset, `avg_freq` is 0, `hist_valid` is 0, and `s_ready` is 0 while `locked` is low.
- R2: `s_ready` equals `locked` AND (`locked` one cycle earlier). On the first cycle `locked` is high, `s_ready` is low. Samples offered while `s_ready` is low are not counted into the history.
- R3: On the clock edge where `locked` is first seen high, the window exponent is captured and clamped to the range 1..MAX_EXP. The delay exponent is captured and clamped to the range 0..MAX_EXP. With these values, window W = 2^L - 1 and delay D = 2^Dx.
- R4: `hist_valid` becomes 1 on the accepting edge of the (D+W)-th sample since the last relock. It stays 1 until the next relock.
- R5: On every accepting edge where `hist_valid` is (or becomes) 1, `avg_freq` is set to floor(S / 2^L). S is the sum of the accepted samples whose age is D through D+W-1, where the newest sample has age 0.
- R6: While `hist_valid` is 0, `avg_freq` keeps its previous value. This includes the value from before a relock.
- R7: While `locked` is low, `avg_freq` and `hist_valid` do not change.
- R8: A rising edge of `locked` clears the history. `hist_valid` is 0 on the cycle after that edge.
- R9: While locked, one sample can be accepted on every clock, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| locked | input | 1 | Loop-locked indication |
| win_exp | input | 5 | Window exponent L (window = 2^L - 1 samples) |
| dly_exp | input | 5 | Delay exponent (skipped region = 2^Dx samples) |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_freq | input | DATA_W | Frequency word sample |
| avg_freq | output | DATA_W | Averaged holdover frequency |
| hist_valid | output | 1 | History covers delay plus window |

## Verification
The bench uses three input patterns, and each one tells apart a different failure.

- A linear ramp with a small window and a two-sample delay shows whether the window is aligned to the right sample ages. An offset of one shifts the result by a full ramp step.
- A constant run followed by large spikes inside the delay region shows whether the delay region is truly excluded, since any leak moves the average away from the constant.
- An alternating pattern with both exponents far above the cap checks the clamping and the exact sample on which `hist_valid` rises. It also checks that the old average is held while the history refills after a relock.

Offering samples while unlocked, and then dropping lock after a fill, shows whether unlocked traffic is ignored and whether the output stays frozen.

// File: rtl/freq_hist_pkg.sv
package freq_hist_pkg;

  localparam int EXP_FIELD_W = 5;

  // Limit a raw exponent field to [lo, hi]
  function automatic int unsigned clamp_exp(input logic [EXP_FIELD_W-1:0] e,
                                            input int unsigned lo,
                                            input int unsigned hi);
    int unsigned v;
    v = int'(e);
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

endpackage

// File: rtl/freq_hist_ctrl.sv
module freq_hist_ctrl
  import freq_hist_pkg::*;
#(
  parameter int MAX_EXP = 6,
  parameter int AW      = MAX_EXP + 1,
  parameter int EW      = $clog2(MAX_EXP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   locked,
  input  logic                   s_valid,
  input  logic [EXP_FIELD_W-1:0] win_exp,
  input  logic [EXP_FIELD_W-1:0] dly_exp,
  output logic                   s_ready,
  output logic                   accept,
  output logic                   clear,
  output logic [AW-1:0]          wr_addr,
  output logic [AW-1:0]          add_addr,
  output logic [AW-1:0]          drop_addr,
  output logic                   add_ok,
  output logic                   drop_ok,
  output logic                   valid_next,
  output logic [EW-1:0]          win_sh
);

  logic          lock_q;
  logic [EW-1:0] l_q, d_q;
  logic [AW-1:0] wp, cnt, cnt_n;
  logic [AW-1:0] span_d, span_w, need;

  assign clear   = locked & ~lock_q;
  assign s_ready = locked & lock_q;
  assign accept  = s_valid & s_ready;

  // delay span, window span and total span of the current session
  assign span_d = AW'(1) << d_q;
  assign span_w = (AW'(1) << l_q) - AW'(1);
  assign need   = span_d + span_w;

  // newest sample goes to wp; age k sits at wp - k after the write
  assign wr_addr   = wp;
  assign add_addr  = wp - span_d;
  assign drop_addr = wp - need;

  assign add_ok     = (cnt >= span_d);
  assign drop_ok    = (cnt >= need);
  assign cnt_n      = drop_ok ? cnt : cnt + AW'(1);
  assign valid_next = (cnt_n == need);
  assign win_sh     = l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      l_q    <= EW'(1);
      d_q    <= '0;
      wp     <= '0;
      cnt    <= '0;
    end else begin
      lock_q <= locked;
      if (clear) begin
        cnt <= '0;
        l_q <= EW'(clamp_exp(win_exp, 1, MAX_EXP));
        d_q <= EW'(clamp_exp(dly_exp, 0, MAX_EXP));
      end else if (accept) begin
        wp  <= wp + AW'(1);
        cnt <= cnt_n;
      end
    end
  end

endmodule

// File: rtl/freq_hist_ring.sv
module freq_hist_ring #(
  parameter int DATA_W = 24,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     ra_addr,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

endmodule

// File: rtl/freq_hist_accum.sv
module freq_hist_accum #(
  parameter int DATA_W = 24,
  parameter int AW     = 7,
  parameter int EW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic              add_ok,
  input  logic              drop_ok,
  input  logic [DATA_W-1:0] add_val,
  input  logic [DATA_W-1:0] drop_val,
  input  logic              valid_next,
  input  logic [EW-1:0]     win_sh,
  output logic [DATA_W-1:0] avg_freq,
  output logic              hist_valid
);

  localparam int SW = DATA_W + AW;

  logic [SW-1:0]     sum_q, sum_n, add_term, drop_term;
  logic [DATA_W-1:0] avg_n;

  assign add_term  = add_ok  ? SW'(add_val)  : '0;
  assign drop_term = drop_ok ? SW'(drop_val) : '0;
  assign sum_n     = sum_q + add_term - drop_term;
  assign avg_n     = DATA_W'(sum_n >> win_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q      <= '0;
      avg_freq   <= '0;
      hist_valid <= 1'b0;
    end else if (clear) begin
      sum_q      <= '0;
      hist_valid <= 1'b0;
    end else if (accept) begin
      sum_q      <= sum_n;
      hist_valid <= valid_next;
      if (valid_next) avg_freq <= avg_n;
    end
  end

endmodule

// File: rtl/freq_hist_avg.sv
module freq_hist_avg
  import freq_hist_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int MAX_EXP = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   locked,
  input  logic [EXP_FIELD_W-1:0] win_exp,
  input  logic [EXP_FIELD_W-1:0] dly_exp,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [DATA_W-1:0]      s_freq,
  output logic [DATA_W-1:0]      avg_freq,
  output logic                   hist_valid
);

  localparam int AW = MAX_EXP + 1;
  localparam int EW = $clog2(MAX_EXP + 1);

  logic              accept, clear, add_ok, drop_ok, valid_next;
  logic [AW-1:0]     wr_addr, add_addr, drop_addr;
  logic [EW-1:0]     win_sh;
  logic [DATA_W-1:0] add_val, drop_val;

  freq_hist_ctrl #(.MAX_EXP(MAX_EXP), .AW(AW), .EW(EW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked),
    .s_valid    (s_valid),
    .win_exp    (win_exp),
    .dly_exp    (dly_exp),
    .s_ready    (s_ready),
    .accept     (accept),
    .clear      (clear),
    .wr_addr    (wr_addr),
    .add_addr   (add_addr),
    .drop_addr  (drop_addr),
    .add_ok     (add_ok),
    .drop_ok    (drop_ok),
    .valid_next (valid_next),
    .win_sh     (win_sh)
  );

  freq_hist_ring #(.DATA_W(DATA_W), .AW(AW)) u_ring (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (wr_addr),
    .wr_data (s_freq),
    .ra_addr (add_addr),
    .rb_addr (drop_addr),
    .ra_data (add_val),
    .rb_data (drop_val)
  );

  freq_hist_accum #(.DATA_W(DATA_W), .AW(AW), .EW(EW)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .accept     (accept),
    .add_ok     (add_ok),
    .drop_ok    (drop_ok),
    .add_val    (add_val),
    .drop_val   (drop_val),
    .valid_next (valid_next),
    .win_sh     (win_sh),
    .avg_freq   (avg_freq),
    .hist_valid (hist_valid)
  );

endmodule

// File: rtl/freq_hist_chk.sv
module freq_hist_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] avg_freq,
  input logic              hist_valid
);

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> locked);

  // R2
  ready_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !s_ready);

  // R8
  relock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |=> !hist_valid);

  // R6
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(avg_freq));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hist_valid) |-> $past(s_valid && s_ready));

  // R7
  valid_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(hist_valid));

endmodule

bind freq_hist_avg freq_hist_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .locked     (locked),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .avg_freq   (avg_freq),
  .hist_valid (hist_valid)
);

// File: tb/freq_hist_avg_test.sv
module freq_hist_avg_test;

  localparam int DW   = 24;
  localparam int MAXE = 6;

  typedef struct packed {
    logic [DW-1:0] avg;
    logic          vld;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          locked = 1'b0;
  logic [4:0]    win_exp = '0;
  logic [4:0]    dly_exp = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_freq = '0;
  logic [DW-1:0] avg_freq;
  logic          hist_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  exp_t          sb_q[$];
  logic [DW-1:0] hist[$];
  int            mL = 1, mD = 1;
  logic [DW-1:0] m_avg = '0;

  freq_hist_avg #(.DATA_W(DW), .MAX_EXP(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .locked(locked), .win_exp(win_exp),
    .dly_exp(dly_exp), .s_valid(s_valid), .s_ready(s_ready),
    .s_freq(s_freq), .avg_freq(avg_freq), .hist_valid(hist_valid)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int clampv(input int e, input int lo, input int hi);
    if (e < lo) return lo;
    if (e > hi) return hi;
    return e;
  endfunction

  // Driver: one accepted sample per clock, expected result into the scoreboard
  task automatic send(input logic [DW-1:0] x);
    int w, need;
    longint sum;
    bit vld;
    check("R9 ready during stream", 64'(s_ready), 64'd1);
    s_valid = 1'b1;
    s_freq  = x;
    hist.push_front(x);
    if (hist.size() > 128) void'(hist.pop_back());
    w    = (1 << mL) - 1;
    need = (1 << mD) + w;
    vld  = (hist.size() >= need);
    if (vld) begin
      sum = 0;
      for (int k = (1 << mD); k < need; k++) sum += longint'(hist[k]);
      m_avg = DW'(sum >> mL);
    end
    sb_q.push_back('{avg: m_avg, vld: vld});
    @(negedge clk);
  endtask

  task automatic do_lock(input int w, input int d);
    locked = 1'b0;
    s_valid = 1'b0;
    @(negedge clk);
    win_exp = 5'(w);
    dly_exp = 5'(d);
    locked = 1'b1;
    check("R2 ready low on first locked cycle", 64'(s_ready), 64'd0);
    @(negedge clk);
    hist.delete();
    mL = clampv(w, 1, MAXE);
    mD = clampv(d, 0, MAXE);
    check("R8 valid cleared on relock", 64'(hist_valid), 64'd0);
    check("R2 ready after lock settles", 64'(s_ready), 64'd1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor: compare the outputs after each accepting edge
  initial begin
    forever begin
      @(posedge clk);
      if (s_valid && s_ready) begin
        exp_t e;
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check("R5 unexpected accept", 64'd1, 64'd0);
        end else begin
          e = sb_q.pop_front();
          check("R4 hist_valid", 64'(hist_valid), 64'(e.vld));
          check("R5 R6 avg_freq", 64'(avg_freq), 64'(e.avg));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 avg after reset", 64'(avg_freq), 64'd0);
    check("R1 valid after reset", 64'(hist_valid), 64'd0);
    check("R1 ready after reset", 64'(s_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: samples offered while unlocked must be dropped
    s_valid = 1'b1;
    s_freq  = 24'hABCDEF;
    for (int i = 0; i < 5; i++) begin
      check("R2 ready low while unlocked", 64'(s_ready), 64'd0);
      @(negedge clk);
    end

    // Ramp, L=2 (W=3), Dx=1 (D=2): valid on 5th sample
    do_lock(2, 1);
    for (int i = 1; i <= 10; i++) send(DW'(10 * i));
    s_valid = 1'b0;
    @(negedge clk);
    check("R5 ramp average", 64'(avg_freq), 64'd52);

    // R7: unlock, outputs frozen while traffic is offered
    locked = 1'b0;
    held = avg_freq;
    s_valid = 1'b1;
    s_freq = 24'h777777;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R7 avg frozen", 64'(avg_freq), 64'(held));
      check("R7 valid frozen", 64'(hist_valid), 64'd1);
    end

    // Constant then spikes inside delay region; L=0 clamps to 1, D=8
    do_lock(0, 3);
    for (int i = 0; i < 12; i++) send(24'd500);
    for (int i = 0; i < 8; i++) send(24'd9000);
    s_valid = 1'b0;
    @(negedge clk);
    check("R5 delay region excluded", 64'(avg_freq), 64'd250);
    check("R4 valid after fill", 64'(hist_valid), 64'd1);

    // R3: exponents 31 clamp to 6 -> W=63, D=64, valid on 127th
    do_lock(31, 31);
    for (int i = 0; i < 130; i++)
      send((i % 2 != 0) ? DW'(24'h00F000 + i) : DW'(24'h000123 + i));
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", 64'(sb_q.size()), 64'd0);
    summary();
  end

endmodule